// File: doc/BRIEF.md
# Audio Serial Frame Timer

This block produces the frame timing for a serial audio port. As clock master it divides a fast internal clock down to a bit clock and builds a frame-sync waveform from it, driving both onto pads. As clock slave it takes the bit clock and frame sync from pads through a two-stage synchronizer. Both signals have separate pad-to-logic and logic-to-pad inversion controls. Everything runs on the single internal clock, and the bit clock is handled as a sampled signal whose transitions are detected in that clock domain.

The frame sync is sampled on rising transitions of the internal bit clock. A transition in the selected direction marks a frame start. The frame-start strobe can then be delayed by zero to five half bit-clock periods, counted as transitions of either polarity of the internal bit clock. The outputs are a one-cycle frame-start pulse and a counter of bit clocks within the frame. Configuration is loaded through a write strobe, and the write takes effect only while the port is disabled.

Top module: `audio_frame_timer`

## Requirements
- R1: With `cfgMaster`=1 and `portEn`=1, `padOe` is 1 and the pads carry the generated bit clock and frame sync. With `cfgMaster`=0 (the reset value), `padOe` is 0 and internal timing follows `sclkPadIn`/`fsPadIn`, each delayed by two clock cycles.
- R2: `sclkPadOut` is the generated bit clock XOR the bit-clock output-invert bit (reset 1). While the port is disabled the generated bit clock rests at 0, so the pad rests at the value of the invert bit.
- R3: In slave mode the internal bit clock is the synchronized `sclkPadIn` XOR the bit-clock input-invert bit (reset 1).
- R4: The frame-sync output-invert bit and the frame-sync input-invert bit (both reset 0) apply in the same way to `fsPadOut` and to `fsPadIn`.
- R5: The internal frame sync is sampled on each rising internal bit-clock transition. A frame starts when the sampled value changes to 1 with `cfgStartRise`=1, or to 0 with `cfgStartRise`=0 (the reset value).
- R6: With delay code d in 0..5 (reset 2), `frameStart` rises one clock cycle after the d-th internal bit-clock transition, of either polarity, that follows the start transition. For d=0 it rises one cycle after the start transition itself.
- R7: Delay codes 6 and 7 act as code 0, and accepting one sets `cfgErr`, which stays 1 until reset.
- R8: `frameStart` is one clock cycle wide. `bitCount` is 0 in that cycle and then grows by 1 one cycle after each rising internal bit-clock transition. It is 0 while the port is disabled.
- R9: In master mode a bit-clock half period lasts `cfgDivHalf` clock cycles (0 acts as 1). With `cfgFixedDuty`=1 (the reset value) the internal frame sync is 1 for `cfgHalfCnt` bit clocks and then 0 for `cfgHalfCnt` bit clocks.
- R10: With `cfgFixedDuty`=0 the master frame sync is 1 for `cfgHighCnt` bit clocks out of a `cfgPeriodCnt` bit-clock period. In every master case the frame sync changes only on falling internal bit-clock transitions, and it is 1 at the start of an enable.
- R11: `cfgWe` loads every configuration input only while `portEn`=0. A write made while `portEn`=1 changes no behaviour, including `cfgErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; 0 also permits configuration writes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMaster | input | 1 | 1 master, 0 slave |
| cfgSclkOutInv | input | 1 | Invert bit clock toward pad |
| cfgSclkInInv | input | 1 | Invert bit clock from pad |
| cfgFsOutInv | input | 1 | Invert frame sync toward pad |
| cfgFsInInv | input | 1 | Invert frame sync from pad |
| cfgStartRise | input | 1 | 1 frame starts on rising frame sync, 0 on falling |
| cfgFixedDuty | input | 1 | 1 fixed 50% frame sync, 0 programmable |
| cfgDelay | input | 3 | Frame-start delay in half bit-clock periods |
| cfgDivHalf | input | DIV_W | Clock cycles per bit-clock half period |
| cfgHalfCnt | input | CNT_W | Bit clocks per half frame (fixed duty) |
| cfgHighCnt | input | CNT_W | Bit clocks high (programmable) |
| cfgPeriodCnt | input | CNT_W | Bit clocks per frame (programmable) |
| sclkPadIn | input | 1 | Bit clock from pad |
| fsPadIn | input | 1 | Frame sync from pad |
| sclkPadOut | output | 1 | Bit clock to pad |
| fsPadOut | output | 1 | Frame sync to pad |
| padOe | output | 1 | Pad output enable |
| frameStart | output | 1 | One-cycle frame-start pulse |
| bitCount | output | CNT_W+1 | Rising bit clocks since frame start |
| cfgErr | output | 1 | Sticky reserved-delay flag |

## Verification
The bench builds the block with DIV_W=4 and CNT_W=5. These values keep frames down to a few dozen clock cycles, so every delay code, both start edges, both duty modes and both clock directions fit in a short run. The reset half-frame count of 16 still fits the narrow field. A frame of 62 bit clocks can be reached without wrapping the 6-bit `bitCount`, and the rest level of every pad after reset is checked.

// File: rtl/aft_pkg.sv
package aft_pkg;
  typedef struct packed {
    logic       master;
    logic       sclkOutInv;
    logic       sclkInInv;
    logic       fsOutInv;
    logic       fsInInv;
    logic       startRise;
    logic       fixedDuty;
    logic [2:0] delay;
  } aft_mode_t;

  typedef struct packed {
    logic fire;
    logic bitTick;
  } aft_strobe_t;

  localparam logic [2:0] MAX_DELAY = 3'd5;
endpackage

// File: rtl/aft_ctrl.sv
module aft_ctrl
  import aft_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             cfgWe,
  input  aft_mode_t        wrMode,
  input  logic [DIV_W-1:0] wrDiv,
  input  logic [CNT_W-1:0] wrHalf,
  input  logic [CNT_W-1:0] wrHigh,
  input  logic [CNT_W-1:0] wrPeriod,
  input  logic             sclkInt,
  input  logic             fsInt,
  output aft_mode_t        mode,
  output logic [DIV_W-1:0] divHalf,
  output logic [CNT_W-1:0] halfCnt,
  output logic [CNT_W-1:0] highCnt,
  output logic [CNT_W-1:0] periodCnt,
  output aft_strobe_t      strobe,
  output logic             cfgErr
);
  localparam aft_mode_t MODE_RST = '{master: 1'b0, sclkOutInv: 1'b1, sclkInInv: 1'b1,
                                     fsOutInv: 1'b0, fsInInv: 1'b0, startRise: 1'b0,
                                     fixedDuty: 1'b1, delay: 3'd2};
  localparam logic [CNT_W-1:0] HALF_RST = CNT_W'(1) << (CNT_W - 1);

  logic       cfgLoad, badCode;
  logic       sclkPrev, fsSamp, pend;
  logic [2:0] remain;
  logic       sclkEdge, sclkRise, startHit, fireNow;

  assign cfgLoad = cfgWe && !portEn;
  assign badCode = wrMode.delay > MAX_DELAY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_RST;
      divHalf   <= DIV_W'(1);
      halfCnt   <= HALF_RST;
      highCnt   <= HALF_RST;
      periodCnt <= '1;
      cfgErr    <= 1'b0;
    end else if (cfgLoad) begin
      mode       <= wrMode;
      mode.delay <= badCode ? 3'd0 : wrMode.delay;
      divHalf    <= wrDiv;
      halfCnt    <= wrHalf;
      highCnt    <= wrHigh;
      periodCnt  <= wrPeriod;
      cfgErr     <= cfgErr | badCode;
    end
  end

  assign sclkEdge = sclkInt != sclkPrev;
  assign sclkRise = sclkInt && !sclkPrev;
  assign startHit = sclkRise && (fsInt != fsSamp) && (fsInt == mode.startRise);

  always_comb begin
    fireNow = 1'b0;
    if (portEn) begin
      if (pend && sclkEdge && remain == 3'd1) fireNow = 1'b1;
      if (startHit && mode.delay == 3'd0) fireNow = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      fsSamp   <= 1'b0;
      pend     <= 1'b0;
      remain   <= 3'd0;
    end else begin
      sclkPrev <= sclkInt;
      if (!portEn) begin
        fsSamp <= fsInt;
        pend   <= 1'b0;
        remain <= 3'd0;
      end else begin
        if (sclkRise) fsSamp <= fsInt;
        if (pend && sclkEdge) begin
          remain <= remain - 3'd1;
          if (remain == 3'd1) pend <= 1'b0;
        end
        if (startHit && mode.delay != 3'd0) begin
          pend   <= 1'b1;
          remain <= mode.delay;
        end
      end
    end
  end

  assign strobe.fire    = fireNow;
  assign strobe.bitTick = portEn && sclkRise;

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (portEn && $past(portEn)) |-> ($stable(mode) && $stable(divHalf) && $stable(halfCnt)
                                   && $stable(highCnt) && $stable(periodCnt)));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !portEn && wrMode.delay > MAX_DELAY) |=> (cfgErr && mode.delay == 3'd0));
endmodule

// File: rtl/aft_datapath.sv
module aft_datapath
  import aft_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  aft_mode_t        mode,
  input  logic [DIV_W-1:0] divHalf,
  input  logic [CNT_W-1:0] halfCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic [CNT_W-1:0] periodCnt,
  input  aft_strobe_t      strobe,
  input  logic             sclkPadIn,
  input  logic             fsPadIn,
  output logic             sclkInt,
  output logic             fsInt,
  output logic             sclkPadOut,
  output logic             fsPadOut,
  output logic             padOe,
  output logic             frameStart,
  output logic [CNT_W:0]   bitCount
);
  localparam int DW1 = DIV_W + 1;
  localparam int BW  = CNT_W + 1;

  logic [1:0]       sclkSync, fsSync;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W:0]   fsCnt, fsNext, highLen, perLen;
  logic             genSclk, genFs, runGen, divHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= 2'b00;
      fsSync   <= 2'b00;
    end else begin
      sclkSync <= {sclkSync[0], sclkPadIn};
      fsSync   <= {fsSync[0], fsPadIn};
    end
  end

  assign runGen  = portEn && mode.master;
  assign divHit  = (DW1'(divCnt) + DW1'(1)) >= DW1'(divHalf);
  assign highLen = mode.fixedDuty ? BW'(halfCnt) : BW'(highCnt);
  assign perLen  = mode.fixedDuty ? {halfCnt, 1'b0} : BW'(periodCnt);
  assign fsNext  = fsCnt + BW'(1);
  assign genFs   = fsCnt < highLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      genSclk <= 1'b0;
      fsCnt   <= '0;
    end else if (!runGen) begin
      divCnt  <= '0;
      genSclk <= 1'b0;
      fsCnt   <= '0;
    end else if (divHit) begin
      divCnt  <= '0;
      genSclk <= !genSclk;
      if (genSclk) fsCnt <= (fsNext >= perLen) ? '0 : fsNext;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign sclkInt    = mode.master ? genSclk : (sclkSync[1] ^ mode.sclkInInv);
  assign fsInt      = mode.master ? genFs : (fsSync[1] ^ mode.fsInInv);
  assign sclkPadOut = genSclk ^ mode.sclkOutInv;
  assign fsPadOut   = genFs ^ mode.fsOutInv;
  assign padOe      = runGen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameStart <= 1'b0;
      bitCount   <= '0;
    end else begin
      frameStart <= strobe.fire;
      if (!portEn || strobe.fire) bitCount <= '0;
      else if (strobe.bitTick)    bitCount <= bitCount + BW'(1);
    end
  end

  p_fs_on_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runGen && $past(runGen) && genFs != $past(genFs)) |-> ($past(genSclk) && !genSclk));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (portEn && $past(portEn) && !frameStart && bitCount != $past(bitCount))
      |-> (bitCount == BW'($past(bitCount) + BW'(1))));
endmodule

// File: rtl/audio_frame_timer.sv
module audio_frame_timer
  import aft_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEn,
  input  logic             cfgWe,
  input  logic             cfgMaster,
  input  logic             cfgSclkOutInv,
  input  logic             cfgSclkInInv,
  input  logic             cfgFsOutInv,
  input  logic             cfgFsInInv,
  input  logic             cfgStartRise,
  input  logic             cfgFixedDuty,
  input  logic [2:0]       cfgDelay,
  input  logic [DIV_W-1:0] cfgDivHalf,
  input  logic [CNT_W-1:0] cfgHalfCnt,
  input  logic [CNT_W-1:0] cfgHighCnt,
  input  logic [CNT_W-1:0] cfgPeriodCnt,
  input  logic             sclkPadIn,
  input  logic             fsPadIn,
  output logic             sclkPadOut,
  output logic             fsPadOut,
  output logic             padOe,
  output logic             frameStart,
  output logic [CNT_W:0]   bitCount,
  output logic             cfgErr
);
  aft_mode_t        wrMode, mode;
  aft_strobe_t      strobe;
  logic [DIV_W-1:0] divHalf;
  logic [CNT_W-1:0] halfCnt, highCnt, periodCnt;
  logic             sclkInt, fsInt;

  assign wrMode = '{master: cfgMaster, sclkOutInv: cfgSclkOutInv, sclkInInv: cfgSclkInInv,
                    fsOutInv: cfgFsOutInv, fsInInv: cfgFsInInv, startRise: cfgStartRise,
                    fixedDuty: cfgFixedDuty, delay: cfgDelay};

  aft_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .portEn(portEn), .cfgWe(cfgWe), .wrMode(wrMode),
    .wrDiv(cfgDivHalf), .wrHalf(cfgHalfCnt), .wrHigh(cfgHighCnt), .wrPeriod(cfgPeriodCnt),
    .sclkInt(sclkInt), .fsInt(fsInt), .mode(mode), .divHalf(divHalf), .halfCnt(halfCnt),
    .highCnt(highCnt), .periodCnt(periodCnt), .strobe(strobe), .cfgErr(cfgErr)
  );

  aft_datapath #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .portEn(portEn), .mode(mode), .divHalf(divHalf),
    .halfCnt(halfCnt), .highCnt(highCnt), .periodCnt(periodCnt), .strobe(strobe),
    .sclkPadIn(sclkPadIn), .fsPadIn(fsPadIn), .sclkInt(sclkInt), .fsInt(fsInt),
    .sclkPadOut(sclkPadOut), .fsPadOut(fsPadOut), .padOe(padOe),
    .frameStart(frameStart), .bitCount(bitCount)
  );

  p_oe_mode_r1: assert property (@(posedge clk) disable iff (!rstN)
    padOe |-> (portEn && $past(cfgMaster | !cfgWe | portEn) && !$isunknown(sclkPadOut)));
endmodule

// File: tb/audio_frame_timer_tb_top.sv
`timescale 1ns/1ps
module audio_frame_timer_tb_top;
  localparam int DIV_W = 4;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEn = 1'b0, cfgWe = 1'b0;
  logic cfgMaster = 0, cfgSclkOutInv = 1, cfgSclkInInv = 1, cfgFsOutInv = 0, cfgFsInInv = 0;
  logic cfgStartRise = 0, cfgFixedDuty = 1;
  logic [2:0] cfgDelay = 3'd2;
  logic [DIV_W-1:0] cfgDivHalf = 1;
  logic [CNT_W-1:0] cfgHalfCnt = 16, cfgHighCnt = 16, cfgPeriodCnt = 31;
  logic sclkPadIn = 0, fsPadIn = 0;
  logic sclkPadOut, fsPadOut, padOe, frameStart, cfgErr;
  logic [CNT_W:0] bitCount;

  always #2.5 clk = ~clk;

  audio_frame_timer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) dut_i (.*);

  int tests = 0, fails = 0;
  int cyc = 0;
  string tag = "R6";
  int aMaster = 0, aSOI = 1, aSII = 1, aFOI = 0, aFII = 0, aRise = 0, aDelay = 2;
  int expQ[$];
  int frames = 0, bitErr = 0;
  int mPrev = 0, mSamp = 0, mPend = 0, mRem = 0, mBit = 0;
  int sH1 = 0, sH2 = 0, fH1 = 0, fH2 = 0;
  int lastFs = 1, lastChg = 0, hiDur = 0, loDur = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model of the requirement-level timing, fed from the pads
  always @(negedge clk) begin
    if (rstN) begin
      int s, f, rise, edgeAny, fire;
      s = aMaster ? (sclkPadOut ^ aSOI) : (sH2 ^ aSII);
      f = aMaster ? (fsPadOut ^ aFOI) : (fH2 ^ aFII);
      sH2 = sH1; sH1 = sclkPadIn; fH2 = fH1; fH1 = fsPadIn;
      if (int'(bitCount) != mBit) bitErr++;
      if (fsPadOut != lastFs) begin
        if (lastFs == 1) hiDur = cyc - lastChg; else loDur = cyc - lastChg;
        lastFs = fsPadOut; lastChg = cyc;
      end
      fire = 0;
      if (!portEn) begin
        mSamp = f; mPend = 0; mBit = 0;
      end else begin
        rise = s && !mPrev;
        edgeAny = s != mPrev;
        if (mPend && edgeAny) begin
          if (mRem == 1) begin fire = 1; mPend = 0; end
          mRem--;
        end
        if (rise && f != mSamp && f == aRise) begin
          if (aDelay == 0) fire = 1;
          else begin mPend = 1; mRem = aDelay; end
        end
        if (rise) mSamp = f;
        if (fire) mBit = 0; else if (rise) mBit++;
        if (fire) expQ.push_back(cyc + 1);
      end
      mPrev = s;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      while (expQ.size() > 0 && expQ[0] < cyc) begin
        chk(0, tag, "missing frameStart at cycle", 0, expQ[0]);
        void'(expQ.pop_front());
      end
      if (frameStart) begin
        if (expQ.size() > 0 && expQ[0] == cyc) begin
          void'(expQ.pop_front());
          frames++;
          chk(bitCount == 0, "R8", "bitCount at frame start", int'(bitCount), 0);
        end else begin
          chk(0, tag, "unexpected frameStart at cycle", cyc, expQ.size() > 0 ? expQ[0] : -1);
        end
      end
    end
  end

  task automatic writeCfg(input int ms, input int soi, input int sii, input int foi, input int fii,
                          input int rs, input int fx, input int dl, input int dv, input int hf,
                          input int hi, input int pr);
    @(posedge clk); #1;
    cfgMaster = ms[0]; cfgSclkOutInv = soi[0]; cfgSclkInInv = sii[0]; cfgFsOutInv = foi[0];
    cfgFsInInv = fii[0]; cfgStartRise = rs[0]; cfgFixedDuty = fx[0]; cfgDelay = dl[2:0];
    cfgDivHalf = dv[DIV_W-1:0]; cfgHalfCnt = hf[CNT_W-1:0]; cfgHighCnt = hi[CNT_W-1:0];
    cfgPeriodCnt = pr[CNT_W-1:0]; cfgWe = 1;
    @(posedge clk); #1;
    cfgWe = 0;
    if (!portEn) begin
      aMaster = ms; aSOI = soi; aSII = sii; aFOI = foi; aFII = fii; aRise = rs;
      aDelay = (dl > 5) ? 0 : dl;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic enablePort();
    frames = 0; bitErr = 0;
    @(posedge clk); #1 portEn = 1;
  endtask

  task automatic closePhase(input int minFrames);
    @(posedge clk); #1 portEn = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(expQ.size() == 0, tag, "expected frames left over", expQ.size(), 0);
    chk(frames >= minFrames, tag, "frames seen", frames, minFrames);
    chk(bitErr == 0, "R8", "bitCount mismatching cycles", bitErr, 0);
  endtask

  task automatic driveSlave(input int cycles, input int halfP, input int bitsHalf, input int chgLevel);
    int ph = 0, bits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      ph++;
      if (ph == halfP) begin
        ph = 0;
        sclkPadIn = ~sclkPadIn;
        if (sclkPadIn == chgLevel[0]) begin
          bits++;
          if (bits == bitsHalf) begin bits = 0; fsPadIn = ~fsPadIn; end
        end
      end
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk(frameStart == 0, "R8", "frameStart after reset", frameStart, 0);
    chk(bitCount == 0, "R8", "bitCount after reset", int'(bitCount), 0);
    chk(cfgErr == 0, "R7", "cfgErr after reset", cfgErr, 0);
    chk(padOe == 0, "R1", "padOe after reset (slave)", padOe, 0);
    chk(sclkPadOut == 1, "R2", "sclk pad rest level after reset (inverted)", sclkPadOut, 1);
    chk(fsPadOut == 1, "R4", "fs pad level after reset (normal)", fsPadOut, 1);

    // R9 fixed duty master, default delay code 2, falling start
    tag = "R6";
    writeCfg(1, 1, 1, 0, 0, 0, 1, 2, 2, 4, 0, 0);
    enablePort();
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(padOe == 1, "R1", "padOe in master", padOe, 1);
    chk(hiDur == 16, "R9", "fs high cycles", hiDur, 16);
    chk(loDur == 16, "R9", "fs low cycles", loDur, 16);
    // R11 writes while enabled are ignored
    writeCfg(1, 0, 0, 1, 1, 1, 0, 6, 1, 2, 1, 3);
    tag = "R11";
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(cfgErr == 0, "R11", "cfgErr after write while enabled", cfgErr, 0);
    chk(hiDur == 16, "R11", "fs high cycles after ignored write", hiDur, 16);
    closePhase(10);
    chk(sclkPadOut == 1, "R2", "sclk pad rest, invert on", sclkPadOut, 1);

    // R6 / R5 every legal delay code, both start edges
    for (int d = 0; d < 6; d++) begin
      tag = (d % 2 == 0) ? "R6" : "R5";
      writeCfg(1, 0, 1, 0, 0, d % 2, 1, d, 3, 3, 0, 0);
      enablePort();
      repeat (300) @(posedge clk);
      closePhase(5);
    end
    chk(sclkPadOut == 0, "R2", "sclk pad rest, invert off", sclkPadOut, 0);

    // R10 programmable duty, R4 fs output inversion
    tag = "R10";
    writeCfg(1, 0, 1, 1, 0, 1, 0, 1, 2, 0, 3, 10);
    enablePort();
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(hiDur == 28, "R4", "inverted fs pad high cycles", hiDur, 28);
    chk(loDur == 12, "R10", "inverted fs pad low cycles", loDur, 12);
    closePhase(5);

    // R7 reserved codes behave as zero delay
    tag = "R7";
    writeCfg(1, 1, 1, 0, 0, 0, 1, 6, 1, 5, 0, 0);
    chk(cfgErr == 1, "R7", "cfgErr after reserved code 6", cfgErr, 1);
    enablePort();
    repeat (200) @(posedge clk);
    closePhase(5);
    writeCfg(1, 1, 1, 0, 0, 1, 1, 7, 2, 3, 0, 0);
    enablePort();
    repeat (200) @(posedge clk);
    closePhase(5);
    writeCfg(1, 1, 1, 0, 0, 0, 1, 3, 2, 3, 0, 0);
    chk(cfgErr == 1, "R7", "cfgErr stays set after legal code", cfgErr, 1);

    // R3 / R4 slave mode with both bit-clock input polarities
    for (int inv = 0; inv < 2; inv++) begin
      tag = "R3";
      writeCfg(0, 0, inv, 0, 1, inv, 1, 3 + inv, 1, 4, 0, 0);
      enablePort();
      @(negedge clk);
      chk(padOe == 0, "R1", "padOe in slave while enabled", padOe, 0);
      driveSlave(700, 3, 8, inv);
      closePhase(4);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule